// File: doc/BRIEF.md
# Multi-Master Hardware Semaphore Bank

This block holds a set of hardware lock cells that several processors share to coordinate access to common resources. A processor takes a lock by storing its nonzero 4-bit requester number into that lock's word. It then reads the word back, and it holds the lock only if the low nibble matches its own number. Storing zero hands the lock back. No interrupts are involved: a requester that loses simply polls again later.

Two independent register-bus ports reach the bank, each with write strobe, read strobe, byte address, write data and registered read data. Each lock cell is a two-state machine: state `SEM_FREE` and state `SEM_HELD`. The transitions are CLAIM_P0 (FREE to HELD, taken on a nonzero port-0 write), CLAIM_P1 (FREE to HELD on a nonzero port-1 write when port 0 does not claim), RELEASE (HELD to FREE on a zero-nibble write from either port), and STAY (every other case, including nonzero writes to a held cell). A control word with a protocol-select flag and a write-only clear-all word complete the map.

Top module: `hsem_bank`

## Requirements
- R1: The bank has NUM_SEM (default 32) independent lock cells; cell i sits at byte offset 0x08 + 4*i, and after reset `rst` every cell reads 0 (free).
- R2: A write whose bits [3:0] are nonzero to a free cell makes it held by that value; a later read returns that value in bits [3:0] with bits [31:4] zero.
- R3: A write whose bits [3:0] are zero to a held cell frees it, whichever port issues it.
- R4: A write with nonzero bits [3:0] to a cell that is already held leaves the stored owner unchanged.
- R5: When both ports write nonzero values to the same free cell in one cycle, the port-0 value becomes the owner; writes to two different cells in one cycle both take effect.
- R6: Only bits [3:0] of a write to a cell are stored; bits [31:4] of the write are ignored (so 0x10 frees a cell).
- R7: The control word at offset 0x00 resets to 0, stores all 32 written bits and reads them back; bit 0 is the protocol flag (0 = polled, no interrupts); if both ports write it in one cycle, port 0's data is kept.
- R8: Read data appears on the edge after the read strobe is sampled (one-cycle latency) and is 0 on any cycle that follows a cycle without a read strobe.
- R9: The clear-all word at offset 0x90 accepts writes and reads 0; unmapped or unaligned offsets (such as 0x04, 0x88, 0x0A) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| p0_wen | input | 1 | Port 0 write strobe |
| p0_ren | input | 1 | Port 0 read strobe |
| p0_addr | input | 8 | Port 0 byte address |
| p0_wdata | input | 32 | Port 0 write data |
| p0_rdata | output | 32 | Port 0 read data, registered |
| p1_wen | input | 1 | Port 1 write strobe |
| p1_ren | input | 1 | Port 1 read strobe |
| p1_addr | input | 8 | Port 1 byte address |
| p1_wdata | input | 32 | Port 1 write data |
| p1_rdata | output | 32 | Port 1 read data, registered |

## Verification
The bench builds the bank with its defaults: 32 cells, 4-bit owner numbers, 8-bit addresses and 32-bit data. With that size the first and last cells (0x08 and 0x84) and the first offset past the map (0x88) are all reachable, as is the clear-all word at 0x90. The two ports let the bench place colliding claims on one free cell, parallel claims on separate cells, and a release from a port that did not claim.

// File: rtl/hsem_pkg.sv
package hsem_pkg;
    localparam int CTRL_OFS   = 'h00;
    localparam int SEM_BASE   = 'h08;
    localparam int SEM_STRIDE = 4;
    localparam int CLR_OFS    = 'h90;

    typedef enum logic {
        SEM_FREE = 1'b0,
        SEM_HELD = 1'b1
    } sem_state_e;
endpackage

// File: rtl/hsem_dec.sv
module hsem_dec
    import hsem_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int NUM_SEM = 32,
    parameter int IDX_W   = $clog2(NUM_SEM)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              sem_hit,
    output logic [IDX_W-1:0]  sem_idx,
    output logic              ctrl_hit
);
    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] slot;

    always_comb begin
        off      = addr - ADDR_W'(SEM_BASE);
        slot     = off >> 2;
        sem_hit  = (addr >= ADDR_W'(SEM_BASE)) && (off[1:0] == 2'b00)
                   && (slot < ADDR_W'(NUM_SEM));
        sem_idx  = slot[IDX_W-1:0];
        ctrl_hit = (addr == ADDR_W'(CTRL_OFS));
    end
endmodule

// File: rtl/hsem_cell.sv
module hsem_cell
    import hsem_pkg::*;
#(
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr0,
    input  logic [ID_W-1:0] id0,
    input  logic            wr1,
    input  logic [ID_W-1:0] id1,
    output logic [ID_W-1:0] owner
);
    sem_state_e      state_q, state_d;
    logic [ID_W-1:0] own_q, own_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEM_FREE;
            own_q   <= '0;
        end else begin
            state_q <= state_d;
            own_q   <= own_d;
        end
    end

    // next state: CLAIM_P0, CLAIM_P1, RELEASE, STAY
    always_comb begin
        state_d = state_q;
        own_d   = own_q;
        unique case (state_q)
            SEM_FREE: begin
                if (wr0 && (id0 != '0)) begin
                    state_d = SEM_HELD;
                    own_d   = id0;
                end else if (wr1 && (id1 != '0)) begin
                    state_d = SEM_HELD;
                    own_d   = id1;
                end
            end
            SEM_HELD: begin
                if ((wr0 && (id0 == '0)) || (wr1 && (id1 == '0))) begin
                    state_d = SEM_FREE;
                    own_d   = '0;
                end
            end
            default: begin
                state_d = SEM_FREE;
                own_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        owner = (state_q == SEM_HELD) ? own_q : '0;
    end
endmodule

// File: rtl/hsem_rdport.sv
module hsem_rdport #(
    parameter int DATA_W  = 32,
    parameter int ID_W    = 4,
    parameter int NUM_SEM = 32,
    parameter int IDX_W   = $clog2(NUM_SEM)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ren,
    input  logic              sem_hit,
    input  logic [IDX_W-1:0]  sem_idx,
    input  logic              ctrl_hit,
    input  logic [ID_W-1:0]   own [NUM_SEM],
    input  logic [DATA_W-1:0] ctrl,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] rd_d;

    always_comb begin
        rd_d = '0;
        if (ren) begin
            if (ctrl_hit)
                rd_d = ctrl;
            else if (sem_hit)
                rd_d = DATA_W'(own[sem_idx]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd_d;
    end
endmodule

// File: rtl/hsem_bank.sv
module hsem_bank #(
    parameter int NUM_SEM = 32,
    parameter int ID_W    = 4,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              p0_wen,
    input  logic              p0_ren,
    input  logic [ADDR_W-1:0] p0_addr,
    input  logic [DATA_W-1:0] p0_wdata,
    output logic [DATA_W-1:0] p0_rdata,
    input  logic              p1_wen,
    input  logic              p1_ren,
    input  logic [ADDR_W-1:0] p1_addr,
    input  logic [DATA_W-1:0] p1_wdata,
    output logic [DATA_W-1:0] p1_rdata
);
    localparam int NPORT = 2;
    localparam int IDX_W = $clog2(NUM_SEM);

    logic [NPORT-1:0]  wen, ren, sem_hit, ctrl_hit;
    logic [ADDR_W-1:0] addr  [NPORT];
    logic [DATA_W-1:0] wdata [NPORT];
    logic [DATA_W-1:0] rdata [NPORT];
    logic [IDX_W-1:0]  sem_idx [NPORT];
    logic [ID_W-1:0]   own [NUM_SEM];
    logic [DATA_W-1:0] ctrl_q;

    assign wen      = {p1_wen, p0_wen};
    assign ren      = {p1_ren, p0_ren};
    assign addr[0]  = p0_addr;
    assign addr[1]  = p1_addr;
    assign wdata[0] = p0_wdata;
    assign wdata[1] = p1_wdata;
    assign p0_rdata = rdata[0];
    assign p1_rdata = rdata[1];

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        hsem_dec #(.ADDR_W(ADDR_W), .NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_dec (
            .addr     (addr[p]),
            .sem_hit  (sem_hit[p]),
            .sem_idx  (sem_idx[p]),
            .ctrl_hit (ctrl_hit[p])
        );
        hsem_rdport #(.DATA_W(DATA_W), .ID_W(ID_W), .NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_rd (
            .clk      (clk),
            .rst      (rst),
            .ren      (ren[p]),
            .sem_hit  (sem_hit[p]),
            .sem_idx  (sem_idx[p]),
            .ctrl_hit (ctrl_hit[p]),
            .own      (own),
            .ctrl     (ctrl_q),
            .rdata    (rdata[p])
        );
    end

    for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
        logic w0, w1;
        assign w0 = wen[0] && sem_hit[0] && (sem_idx[0] == IDX_W'(i));
        assign w1 = wen[1] && sem_hit[1] && (sem_idx[1] == IDX_W'(i));
        hsem_cell #(.ID_W(ID_W)) u_cell (
            .clk   (clk),
            .rst   (rst),
            .wr0   (w0),
            .id0   (wdata[0][ID_W-1:0]),
            .wr1   (w1),
            .id1   (wdata[1][ID_W-1:0]),
            .owner (own[i])
        );
    end

    // control word: port 0 has priority on a same-cycle write
    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wen[0] && ctrl_hit[0])
            ctrl_q <= wdata[0];
        else if (wen[1] && ctrl_hit[1])
            ctrl_q <= wdata[1];
    end
endmodule

// File: rtl/hsem_bank_chk.sv
module hsem_bank_chk
    import hsem_pkg::*;
#(
    parameter int NUM_SEM = 32,
    parameter int ID_W    = 4,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              p0_wen,
    input logic              p0_ren,
    input logic [ADDR_W-1:0] p0_addr,
    input logic [DATA_W-1:0] p0_wdata,
    input logic [DATA_W-1:0] p0_rdata,
    input logic              p1_wen,
    input logic              p1_ren,
    input logic [ADDR_W-1:0] p1_addr,
    input logic [DATA_W-1:0] p1_wdata,
    input logic [DATA_W-1:0] p1_rdata,
    input logic [ID_W-1:0]   own [NUM_SEM]
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(CLR_OFS);

    AST_P0_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !$past(p0_ren) |-> (p0_rdata == '0)); // R8
    AST_P1_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !$past(p1_ren) |-> (p1_rdata == '0)); // R8
    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(p0_ren && (p0_addr == A_CLR)) |-> (p0_rdata == '0)); // R9
    AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(p0_ren && (p0_addr != A_CTRL)) |-> (p0_rdata[DATA_W-1:ID_W] == '0)); // R6

    for (genvar i = 0; i < NUM_SEM; i++) begin : g_chk
        localparam logic [ADDR_W-1:0] A = ADDR_W'(SEM_BASE + SEM_STRIDE * i);
        logic w0, w1;
        assign w0 = p0_wen && (p0_addr == A);
        assign w1 = p1_wen && (p1_addr == A);

        AST_OWNER_HOLD: assert property (@(posedge clk) disable iff (rst)
            ((own[i] != '0) && ($past(own[i]) != '0)) |-> (own[i] == $past(own[i]))); // R4
        AST_CLAIM_P0: assert property (@(posedge clk) disable iff (rst)
            $past(w0 && (own[i] == '0) && (p0_wdata[ID_W-1:0] != '0))
            |-> (own[i] == $past(p0_wdata[ID_W-1:0]))); // R2
        AST_ARB_PORT0: assert property (@(posedge clk) disable iff (rst)
            $past(w0 && w1 && (own[i] == '0) && (p0_wdata[ID_W-1:0] != '0)
                  && (p1_wdata[ID_W-1:0] != '0))
            |-> (own[i] == $past(p0_wdata[ID_W-1:0]))); // R5
        AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
            $past((own[i] != '0) && ((w0 && (p0_wdata[ID_W-1:0] == '0))
                                  || (w1 && (p1_wdata[ID_W-1:0] == '0))))
            |-> (own[i] == '0)); // R3
    end
endmodule

bind hsem_bank hsem_bank_chk #(
    .NUM_SEM(NUM_SEM), .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst(rst),
    .p0_wen(p0_wen), .p0_ren(p0_ren), .p0_addr(p0_addr), .p0_wdata(p0_wdata), .p0_rdata(p0_rdata),
    .p1_wen(p1_wen), .p1_ren(p1_ren), .p1_addr(p1_addr), .p1_wdata(p1_wdata), .p1_rdata(p1_rdata),
    .own(own)
);

// File: tb/hsem_bank_bench.sv
module hsem_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        p0_wen = 0, p0_ren = 0, p1_wen = 0, p1_ren = 0;
    logic [7:0]  p0_addr = 0, p1_addr = 0;
    logic [31:0] p0_wdata = 0, p1_wdata = 0;
    logic [31:0] p0_rdata, p1_rdata;
    int total = 0, bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsem_bank u_hsem_bank (
        .clk(clk), .rst(rst),
        .p0_wen(p0_wen), .p0_ren(p0_ren), .p0_addr(p0_addr), .p0_wdata(p0_wdata), .p0_rdata(p0_rdata),
        .p1_wen(p1_wen), .p1_ren(p1_ren), .p1_addr(p1_addr), .p1_wdata(p1_wdata), .p1_rdata(p1_rdata)
    );

    // entry: {req[3:0], port, is_read, addr[7:0], data[31:0]}; data = write value or expected read
    localparam logic [45:0] VEC [NV] = '{
        {4'd2, 1'b0, 1'b0, 8'h08, 32'h0000_0003},  // R2 claim cell 0 by id 3
        {4'd2, 1'b0, 1'b1, 8'h08, 32'h0000_0003},
        {4'd2, 1'b1, 1'b1, 8'h08, 32'h0000_0003},
        {4'd4, 1'b1, 1'b0, 8'h08, 32'h0000_0005},  // R4 losing claim
        {4'd4, 1'b1, 1'b1, 8'h08, 32'h0000_0003},
        {4'd3, 1'b1, 1'b0, 8'h08, 32'h0000_0000},  // R3 release from other port
        {4'd3, 1'b0, 1'b1, 8'h08, 32'h0000_0000},
        {4'd6, 1'b1, 1'b0, 8'h84, 32'hFFFF_FFFA},  // R6 last cell, upper bits dropped
        {4'd6, 1'b0, 1'b1, 8'h84, 32'h0000_000A},
        {4'd6, 1'b0, 1'b0, 8'h84, 32'h0000_0010},  // R6 nibble zero frees
        {4'd6, 1'b0, 1'b1, 8'h84, 32'h0000_0000},
        {4'd7, 1'b0, 1'b0, 8'h00, 32'hDEAD_BEEE},  // R7 control word
        {4'd7, 1'b1, 1'b1, 8'h00, 32'hDEAD_BEEE},
        {4'd9, 1'b0, 1'b0, 8'h90, 32'h0000_FFFF},  // R9 clear-all
        {4'd9, 1'b0, 1'b1, 8'h90, 32'h0000_0000},
        {4'd9, 1'b1, 1'b1, 8'h04, 32'h0000_0000},
        {4'd9, 1'b0, 1'b1, 8'h88, 32'h0000_0000},
        {4'd9, 1'b0, 1'b1, 8'h0A, 32'h0000_0000},
        {4'd1, 1'b1, 1'b0, 8'h44, 32'h0000_0007},  // R1 independence
        {4'd1, 1'b0, 1'b1, 8'h40, 32'h0000_0000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        p0_wen = 0; p0_ren = 0; p1_wen = 0; p1_ren = 0;
    endtask

    task automatic op(input string tag, input logic pt, input logic rd,
                      input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        if (pt == 1'b0) begin
            p0_addr = a; p0_wdata = d; p0_wen = !rd; p0_ren = rd;
        end else begin
            p1_addr = a; p1_wdata = d; p1_wen = !rd; p1_ren = rd;
        end
        @(negedge clk);
        idle();
        if (rd) check(tag, pt ? p1_rdata : p0_rdata, d);
    endtask

    task automatic dual_wr(input logic [7:0] a0, input logic [31:0] d0,
                           input logic [7:0] a1, input logic [31:0] d1);
        @(negedge clk);
        p0_addr = a0; p0_wdata = d0; p0_wen = 1;
        p1_addr = a1; p1_wdata = d1; p1_wen = 1;
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: every cell free after reset
        for (int i = 0; i < 32; i++)
            op("R1", i[0], 1'b1, 8'(8 + 4 * i), 32'h0);
        op("R7", 1'b0, 1'b1, 8'h00, 32'h0);

        for (int k = 0; k < NV; k++)
            op($sformatf("R%0d", VEC[k][45:42]), VEC[k][41], VEC[k][40], VEC[k][39:32], VEC[k][31:0]);
        op("R1", 1'b1, 1'b1, 8'h44, 32'h7);

        // R5: colliding claims on one free cell, port 0 wins
        dual_wr(8'h0C, 32'h2, 8'h0C, 32'h9);
        op("R5", 1'b1, 1'b1, 8'h0C, 32'h2);
        // R5: claims on different cells both succeed
        dual_wr(8'h10, 32'h4, 8'h14, 32'h6);
        op("R5", 1'b0, 1'b1, 8'h10, 32'h4);
        op("R5", 1'b0, 1'b1, 8'h14, 32'h6);
        // R7: same-cycle control writes, port 0 kept
        dual_wr(8'h00, 32'h1234_5670, 8'h00, 32'h0BAD_F00D);
        op("R7", 1'b1, 1'b1, 8'h00, 32'h1234_5670);

        // R8: latency and idle zero
        @(negedge clk);
        p0_addr = 8'h0C; p0_ren = 1;
        check("R8", p0_rdata, 32'h0);       // before the capturing edge
        @(negedge clk);
        idle();
        check("R8", p0_rdata, 32'h2);
        @(negedge clk);
        check("R8", p0_rdata, 32'h0);

        // R1: reset clears held cells and control word
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        op("R1", 1'b0, 1'b1, 8'h44, 32'h0);
        op("R1", 1'b0, 1'b1, 8'h0C, 32'h0);
        op("R7", 1'b0, 1'b1, 8'h00, 32'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule